// File: doc/BRIEF.md
# Parking Barrier Motor Controller

This block steers the motor of a parking-lot barrier arm. It watches two light-beam sensors across the lane: the near beam sits on the street side and the far beam on the lot side. It also reads two end-of-travel switches on the arm. From these it produces a two-bit motor command and a motor enable. A vehicle that breaks a beam from the lowered rest position makes the arm rise. The arm stops against its upper switch. Once the vehicle has cleared to the opposite side, the arm is driven down until the lower switch is pressed again.

An occupancy flag from the lot counter stops the arm from rising for arriving vehicles while the lot is full. A vehicle leaving the lot is still let out. The beam inputs come in already synchronized. The limit switches are raw: each one passes through a two-flop synchronizer and a debounce filter before the sequencer acts on it. If both switches report active together, the arm is frozen and a sticky fault flag is raised.

Top module: `barrier_gate_ctrl`

## Requirements
- R1: The motor command `motorCmd` is 2'b10 to raise the arm, 2'b01 to lower it and 2'b00 to stop; the value 2'b11 never appears.
- R2: While the synchronous active-high `rst` is asserted, `motorCmd` is 2'b00, `faultFlag` is 0 and `motorEn` is 0. After release the controller sits in the lowered-idle state and `motorEn` follows the inverse of `lotFull`.
- R3: In idle, a near-only beam pattern ({beamNear,beamFar} = 2'b10) with `lotFull` low starts raising. Raising continues after the lower switch releases.
- R4: While raising, a debounced active upper switch changes the command to 2'b00.
- R5: With the arm up, an arriving vehicle's far-only pattern (2'b01) starts lowering. Lowering continues after the upper switch releases and stops (2'b00) once the lower switch is debounced active.
- R6: In idle with `lotFull` high, `motorEn` is 0 and a near-only pattern leaves the command at 2'b00.
- R7: In idle, a far-only pattern starts raising even with `lotFull` high. `motorEn` stays 1 until the arm is back down. The departing vehicle's near-only pattern starts lowering.
- R8: A limit-switch level that holds for fewer than `DEBOUNCE_CYCLES` clocks after synchronization has no effect on the command.
- R9: When both debounced switches read active, `motorCmd` goes to 2'b00, `motorEn` to 0 and `faultFlag` to 1. All three stay there until reset, even after the switches recover.
- R10: A pass-through pattern seen while the arm is still rising is remembered. Lowering then starts as soon as the upper switch stops the rise, with no further beam change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beamNear | input | 1 | Street-side beam broken (synchronized) |
| beamFar | input | 1 | Lot-side beam broken (synchronized) |
| limUpRaw | input | 1 | Upper end switch, raw, 1 = pressed |
| limDownRaw | input | 1 | Lower end switch, raw, 1 = pressed |
| lotFull | input | 1 | Occupancy counter reports no free space |
| motorCmd | output | 2 | Motor direction command |
| motorEn | output | 1 | Motor driver enable |
| faultFlag | output | 1 | Sticky conflicting-switch fault |

## Verification
The properties assume that the arm physically moves in the direction commanded. They also assume that once a switch has been debounced active, it stays active long enough for the sequencer to see it. Each stimulus vector holds its inputs for well over the synchronizer and debounce latency before anything is sampled. The beams follow realistic passage orders, and the switches change only in the way a moving arm would change them. The exception is the deliberate short glitch and the deliberate both-switches conflict, each aimed at its own requirement.

// File: rtl/gate_pkg.sv
package gate_pkg;

  localparam logic [1:0] CMD_STOP = 2'b00;
  localparam logic [1:0] CMD_UP   = 2'b10;
  localparam logic [1:0] CMD_DOWN = 2'b01;

  // beam pattern encoding {near, far}
  localparam logic [1:0] BEAMS_NEAR_ONLY = 2'b10;
  localparam logic [1:0] BEAMS_FAR_ONLY  = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPENING,
    ST_RAISED,
    ST_CLOSING,
    ST_FAULT
  } gateState_t;

  typedef enum logic {
    DIR_IN,
    DIR_OUT
  } travelDir_t;

  typedef struct packed {
    logic goUp;
    logic goDown;
    logic halt;
    logic gateEn;
    logic raiseFault;
  } gateStrobe_t;

endpackage

// File: rtl/gate_limit_filter.sv
module gate_limit_filter #(
  parameter int   SYNC_STAGES     = 2,
  parameter int   DEBOUNCE_CYCLES = 8,
  parameter logic RESET_LEVEL     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic rawLevel,
  output logic cleanLevel
);

  localparam int CNT_W = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       stableCnt;
  logic                   syncedLevel;

  always_ff @(posedge clk) begin
    if (rst) syncChain <= {SYNC_STAGES{RESET_LEVEL}};
    else     syncChain <= {syncChain[SYNC_STAGES-2:0], rawLevel};
  end

  assign syncedLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stableCnt  <= '0;
      cleanLevel <= RESET_LEVEL;
    end else if (syncedLevel == cleanLevel) begin
      stableCnt <= '0;
    end else if (stableCnt == CNT_LAST) begin
      stableCnt  <= '0;
      cleanLevel <= syncedLevel;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import gate_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        limUpRaw,
  input  logic        limDownRaw,
  input  gateStrobe_t strobe,
  output logic        limUpSeen,
  output logic        limDownSeen,
  output logic [1:0]  motorCmd,
  output logic        motorEn,
  output logic        faultFlag
);

  localparam int NUM_SWITCHES = 2;
  // index 0 = lower switch (pressed at rest), index 1 = upper switch
  localparam logic [NUM_SWITCHES-1:0] REST_LEVELS = 2'b01;

  logic [NUM_SWITCHES-1:0] rawVec;
  logic [NUM_SWITCHES-1:0] cleanVec;

  assign rawVec = {limUpRaw, limDownRaw};

  for (genvar sw = 0; sw < NUM_SWITCHES; sw++) begin : g_switch
    gate_limit_filter #(
      .SYNC_STAGES    (SYNC_STAGES),
      .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
      .RESET_LEVEL    (REST_LEVELS[sw])
    ) i_filter (
      .clk       (clk),
      .rst       (rst),
      .rawLevel  (rawVec[sw]),
      .cleanLevel(cleanVec[sw])
    );
  end

  assign limDownSeen = cleanVec[0];
  assign limUpSeen   = cleanVec[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      motorCmd  <= CMD_STOP;
      motorEn   <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      if (strobe.halt)        motorCmd <= CMD_STOP;
      else if (strobe.goUp)   motorCmd <= CMD_UP;
      else if (strobe.goDown) motorCmd <= CMD_DOWN;
      motorEn <= strobe.gateEn;
      if (strobe.raiseFault) faultFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        beamNear,
  input  logic        beamFar,
  input  logic        lotFull,
  input  logic        limUpSeen,
  input  logic        limDownSeen,
  output gateStrobe_t strobe
);

  gateState_t state, nextState;
  travelDir_t dir, nextDir;
  logic       passed, nextPassed;
  logic [1:0] beams;
  logic       passCue;

  assign beams   = {beamNear, beamFar};
  assign passCue = (dir == DIR_IN) ? (beams == BEAMS_FAR_ONLY)
                                   : (beams == BEAMS_NEAR_ONLY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      dir    <= DIR_IN;
      passed <= 1'b0;
    end else begin
      state  <= nextState;
      dir    <= nextDir;
      passed <= nextPassed;
    end
  end

  always_comb begin
    nextState  = state;
    nextDir    = dir;
    nextPassed = passed;
    strobe     = '0;
    if (limUpSeen && limDownSeen) begin
      nextState         = ST_FAULT;
      strobe.halt       = 1'b1;
      strobe.raiseFault = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          strobe.halt = 1'b1;
          nextPassed  = 1'b0;
          if (beams == BEAMS_NEAR_ONLY && !lotFull) begin
            nextState   = ST_OPENING;
            nextDir     = DIR_IN;
            strobe.halt = 1'b0;
            strobe.goUp = 1'b1;
          end else if (beams == BEAMS_FAR_ONLY) begin
            nextState   = ST_OPENING;
            nextDir     = DIR_OUT;
            strobe.halt = 1'b0;
            strobe.goUp = 1'b1;
          end
        end
        ST_OPENING: begin
          if (passCue) nextPassed = 1'b1;
          if (limUpSeen) begin
            nextState   = ST_RAISED;
            strobe.halt = 1'b1;
          end
        end
        ST_RAISED: begin
          if (passed || passCue) begin
            nextState     = ST_CLOSING;
            nextPassed    = 1'b0;
            strobe.goDown = 1'b1;
          end
        end
        ST_CLOSING: begin
          if (limDownSeen) begin
            nextState   = ST_IDLE;
            strobe.halt = 1'b1;
          end
        end
        ST_FAULT: begin
          strobe.halt       = 1'b1;
          strobe.raiseFault = 1'b1;
        end
        default: begin
          nextState   = ST_IDLE;
          strobe.halt = 1'b1;
        end
      endcase
    end
    if (nextState == ST_FAULT)     strobe.gateEn = 1'b0;
    else if (nextState == ST_IDLE) strobe.gateEn = !lotFull;
    else                           strobe.gateEn = 1'b1;
  end

endmodule

// File: rtl/barrier_gate_ctrl.sv
module barrier_gate_ctrl
  import gate_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       beamNear,
  input  logic       beamFar,
  input  logic       limUpRaw,
  input  logic       limDownRaw,
  input  logic       lotFull,
  output logic [1:0] motorCmd,
  output logic       motorEn,
  output logic       faultFlag
);

  gateStrobe_t strobe;
  logic        limUpSeen;
  logic        limDownSeen;

  gate_fsm i_fsm (
    .clk        (clk),
    .rst        (rst),
    .beamNear   (beamNear),
    .beamFar    (beamFar),
    .lotFull    (lotFull),
    .limUpSeen  (limUpSeen),
    .limDownSeen(limDownSeen),
    .strobe     (strobe)
  );

  gate_datapath #(
    .SYNC_STAGES    (SYNC_STAGES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .limUpRaw   (limUpRaw),
    .limDownRaw (limDownRaw),
    .strobe     (strobe),
    .limUpSeen  (limUpSeen),
    .limDownSeen(limDownSeen),
    .motorCmd   (motorCmd),
    .motorEn    (motorEn),
    .faultFlag  (faultFlag)
  );

endmodule

// File: rtl/gate_checker.sv
module gate_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] motorCmd,
  input logic       motorEn,
  input logic       faultFlag,
  input logic       limUpSeen,
  input logic       limDownSeen
);

  p_cmd_legal_r1: assert property (@(posedge clk) disable iff (rst)
    motorCmd != 2'b11);

  p_reset_quiet_r2: assert property (@(posedge clk)
    rst |=> (motorCmd == 2'b00 && !faultFlag && !motorEn));

  p_top_stops_r4: assert property (@(posedge clk) disable iff (rst)
    (limUpSeen && motorCmd == 2'b10) |=> motorCmd != 2'b10);

  p_bottom_stops_r5: assert property (@(posedge clk) disable iff (rst)
    (limDownSeen && motorCmd == 2'b01) |=> motorCmd != 2'b01);

  p_disabled_still_r6: assert property (@(posedge clk) disable iff (rst)
    !motorEn |-> motorCmd == 2'b00);

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    faultFlag |=> faultFlag);

  p_fault_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    faultFlag |-> (motorCmd == 2'b00 && !motorEn));

endmodule

bind barrier_gate_ctrl gate_checker i_checker (
  .clk        (clk),
  .rst        (rst),
  .motorCmd   (motorCmd),
  .motorEn    (motorEn),
  .faultFlag  (faultFlag),
  .limUpSeen  (limUpSeen),
  .limDownSeen(limDownSeen)
);

// File: tb/test_barrier_gate_ctrl.sv
`timescale 1ns/1ps
module test_barrier_gate_ctrl;

  localparam int SETTLE   = 24;
  localparam int NUM_VEC  = 21;
  localparam int WATCHDOG = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       beamNear = 1'b0;
  logic       beamFar = 1'b0;
  logic       limUpRaw = 1'b0;
  logic       limDownRaw = 1'b1;
  logic       lotFull = 1'b0;
  logic [1:0] motorCmd;
  logic       motorEn;
  logic       faultFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  barrier_gate_ctrl i_barrier_gate_ctrl (
    .clk(clk), .rst(rst), .beamNear(beamNear), .beamFar(beamFar),
    .limUpRaw(limUpRaw), .limDownRaw(limDownRaw), .lotFull(lotFull),
    .motorCmd(motorCmd), .motorEn(motorEn), .faultFlag(faultFlag)
  );

  // {near,far, up, down, full, expCmd[1:0], expEn, expFault}
  localparam logic [8:0] VEC [NUM_VEC] = '{
    9'b00_0_1_0_00_1_0,
    9'b10_0_1_0_10_1_0,
    9'b10_0_0_0_10_1_0,
    9'b11_1_0_0_00_1_0,
    9'b01_1_0_0_01_1_0,
    9'b00_0_0_0_01_1_0,
    9'b00_0_1_0_00_1_0,
    9'b00_0_1_1_00_0_0,
    9'b10_0_1_1_00_0_0,
    9'b00_0_1_1_00_0_0,
    9'b01_0_1_1_10_1_0,
    9'b01_0_0_1_10_1_0,
    9'b11_1_0_1_00_1_0,
    9'b10_1_0_1_01_1_0,
    9'b00_0_0_1_01_1_0,
    9'b00_0_1_1_00_0_0,
    9'b00_0_1_0_00_1_0,
    9'b10_0_1_0_10_1_0,
    9'b01_0_0_0_10_1_0,
    9'b00_1_0_0_01_1_0,
    9'b00_0_1_0_00_1_0
  };

  function automatic string vecTag(int idx);
    if (idx == 0)       return "R2";
    else if (idx <= 2)  return "R3";
    else if (idx == 3)  return "R4";
    else if (idx <= 6)  return "R5";
    else if (idx <= 9)  return "R6";
    else if (idx <= 15) return "R7";
    else if (idx == 16) return "R6";
    else                return "R10";
  endfunction

  task automatic waitCycles(int n);
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  task automatic checkOut(string req, logic [1:0] eCmd, logic eEn, logic eFault);
    total++;
    if (motorCmd !== eCmd || motorEn !== eEn || faultFlag !== eFault) begin
      bad++;
      $display("FAIL %s: cmd=%b en=%b fault=%b expected cmd=%b en=%b fault=%b",
               req, motorCmd, motorEn, faultFlag, eCmd, eEn, eFault);
    end
  endtask

  task automatic drive(logic [1:0] beams, logic up, logic dn, logic full);
    {beamNear, beamFar} = beams;
    limUpRaw = up;
    limDownRaw = dn;
    lotFull = full;
  endtask

  initial begin
    waitCycles(4);
    checkOut("R2", 2'b00, 1'b0, 1'b0);   // R2 held in reset
    rst = 1'b0;
    waitCycles(4);
    checkOut("R2", 2'b00, 1'b1, 1'b0);   // R2 idle, enable with free space

    for (int v = 0; v < NUM_VEC; v++) begin
      drive(VEC[v][8:7], VEC[v][6], VEC[v][5], VEC[v][4]);
      waitCycles(SETTLE);
      checkOut(vecTag(v), VEC[v][3:2], VEC[v][1], VEC[v][0]);
      if (motorCmd == 2'b11) begin
        total++; bad++;
        $display("FAIL R1: cmd=%b expected not 11", motorCmd);
      end
    end

    // R8: short glitch of the upper switch while raising is ignored
    drive(2'b10, 1'b0, 1'b1, 1'b0);
    waitCycles(SETTLE);
    drive(2'b10, 1'b0, 1'b0, 1'b0);
    waitCycles(SETTLE);
    checkOut("R3", 2'b10, 1'b1, 1'b0);
    limUpRaw = 1'b1;
    waitCycles(3);
    limUpRaw = 1'b0;
    waitCycles(SETTLE);
    checkOut("R8", 2'b10, 1'b1, 1'b0);
    limUpRaw = 1'b1;
    waitCycles(SETTLE);
    checkOut("R4", 2'b00, 1'b1, 1'b0);

    // R9: both switches active -> frozen with sticky fault
    limDownRaw = 1'b1;
    waitCycles(SETTLE);
    checkOut("R9", 2'b00, 1'b0, 1'b1);
    drive(2'b01, 1'b0, 1'b1, 1'b0);
    waitCycles(SETTLE);
    checkOut("R9", 2'b00, 1'b0, 1'b1);

    // R2: reset clears the fault
    drive(2'b00, 1'b0, 1'b1, 1'b0);
    rst = 1'b1;
    waitCycles(4);
    checkOut("R2", 2'b00, 1'b0, 1'b0);
    rst = 1'b0;
    waitCycles(SETTLE);
    checkOut("R2", 2'b00, 1'b1, 1'b0);

    // R2: reset in the middle of a rise stops the motor
    drive(2'b10, 1'b0, 1'b1, 1'b0);
    waitCycles(SETTLE);
    checkOut("R3", 2'b10, 1'b1, 1'b0);
    rst = 1'b1;
    waitCycles(3);
    checkOut("R2", 2'b00, 1'b0, 1'b0);
    drive(2'b00, 1'b0, 1'b1, 1'b1);
    rst = 1'b0;
    waitCycles(SETTLE);
    checkOut("R2", 2'b00, 1'b0, 1'b0);   // R2 enable follows full flag

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < WATCHDOG; w++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule